// File: doc/BRIEF.md
# I2C SCL Clock Pacer

This block paces the SCL line of an I2C controller from the system clock. A single timing control word sets three values: a power-of-two prescaler exponent and separate counts for the low and high halves of the SCL period. Each count is stored minus one. A prescaler turns system clocks into ticks. The low phase lasts a fixed number of ticks. The high phase counts only the ticks on which the sampled SCL line actually reads high, so a slave that holds SCL low stretches the period.

The block drives one output that requests SCL to be pulled low. An open-drain pad turns this into the bus level. Two single-cycle strobes tell a byte engine where to act: one in the middle of the low phase, where SDA may change, and one in the middle of the high phase, where SDA is sampled. A transfer engine raises `restart_i` to begin a fresh SCL period aligned to its own start. Dropping `en_i` releases SCL and clears all internal counting.

Top module: `i2c_scl_pacer`

## Requirements
- R1: With the line following the drive, each low phase holds `scl_pull_o` at 1 for exactly (lo+1)·2^base system clocks.
- R2: With the line following the drive, each high phase holds `scl_pull_o` at 0 for exactly (hi+1)·2^base system clocks, so one full period is 2^base·((hi+1)+(lo+1)) clocks.
- R3: The timing word is decoded as follows: base in bits [3:0], lo in bits [15:12], hi in bits [19:16], each 4 bits wide.
- R4: Bits [11:4] and [31:20] of the timing word have no effect on the SCL waveform or on the strobes.
- R5: During the high phase, ticks on which `scl_i` reads 0 are not counted and `scl_pull_o` stays 0. With base = 0, a slave holding the line for S clocks after release lengthens the high phase to S+hi+1 clocks.
- R6: `sda_drive_stb_o` is high for exactly one cycle per low phase, ((lo>>1)+1)·2^base cycles after the first low cycle.
- R7: `sda_sample_stb_o` is high for exactly one cycle per high phase, ((hi>>1)+1)·2^base cycles after the first released cycle (no stretch), or S+(hi>>1)+1 cycles after it under the stretch of R5.
- R8: In the cycle after `en_i` is sampled low, `scl_pull_o` and both strobes are 0, and they stay 0 while disabled. In the cycle after `en_i` is sampled high again, a full low phase as in R1 begins.
- R9: In the cycle after `restart_i` is sampled high while enabled, `scl_pull_o` is 1 and a full low phase as in R1 begins.
- R10: While `rst` is high and in the cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables SCL generation; 0 releases the line and clears the counters |
| restart_i | input | 1 | Starts a fresh SCL period with a low phase |
| timing_i | input | 32 | Timing control word (base [3:0], lo [15:12], hi [19:16]) |
| scl_i | input | 1 | Sampled SCL line level |
| scl_pull_o | output | 1 | 1 requests SCL pulled low; 0 releases it |
| sda_drive_stb_o | output | 1 | One-cycle strobe in the middle of the low phase |
| sda_sample_stb_o | output | 1 | One-cycle strobe in the middle of the high phase |

## Verification
The bench builds the block with its default parameters: a 4-bit exponent field, which gives a 16-bit prescaler, and 4-bit phase counts. This puts the full range of phase counts within reach, from a two-clock period (base, hi and lo all 0) to counts of 15. The exponent is randomised from 0 to 4 and checked once directly at 7, which keeps each period short while still exercising the prescaler alignment of the strobes. Clock stretching is checked with base 0 so that every stretched clock maps to exactly one lost tick.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  // Field positions inside the timing word (decoded by neighbours too).
  localparam int unsigned BASE_LSB = 0;
  localparam int unsigned LO_LSB   = 12;
  localparam int unsigned HI_LSB   = 16;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

endpackage

// File: rtl/scl_word_decode.sv
module scl_word_decode #(
  parameter int WORD_W  = 32,
  parameter int BASE_W  = 4,
  parameter int PHASE_W = 4
) (
  input  logic [WORD_W-1:0]  word_i,
  output logic [BASE_W-1:0]  base_o,
  output logic [PHASE_W-1:0] hi_o,
  output logic [PHASE_W-1:0] lo_o
);
  import i2c_scl_pkg::*;

  assign base_o = word_i[BASE_LSB +: BASE_W];
  assign lo_o   = word_i[LO_LSB   +: PHASE_W];
  assign hi_o   = word_i[HI_LSB   +: PHASE_W];

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
  parameter int BASE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              tick_o
);
  localparam int PRE_W = 1 << BASE_W;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_max;

  assign pre_max = (PRE_W'(1) << base_i) - PRE_W'(1);
  assign tick_o  = !clr_i && (pre_cnt == pre_max);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pre_cnt <= '0;
    end else if (tick_o) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               restart_i,
  input  logic               tick_i,
  input  logic               scl_i,
  input  logic [PHASE_W-1:0] hi_i,
  input  logic [PHASE_W-1:0] lo_i,
  output logic               tick_clr_o,
  output logic               pull_o,
  output logic               low_mid_o,
  output logic               high_mid_o
);
  import i2c_scl_pkg::*;

  scl_phase_e         state;
  logic [PHASE_W-1:0] cnt;
  logic [PHASE_W-1:0] lo_half;
  logic [PHASE_W-1:0] hi_half;

  assign lo_half    = lo_i >> 1;
  assign hi_half    = hi_i >> 1;
  assign tick_clr_o = !en_i || restart_i || (state == PH_IDLE);
  assign pull_o     = (state == PH_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PH_IDLE;
      cnt        <= '0;
      low_mid_o  <= 1'b0;
      high_mid_o <= 1'b0;
    end else begin
      low_mid_o  <= 1'b0;
      high_mid_o <= 1'b0;
      if (!en_i) begin
        state <= PH_IDLE;
        cnt   <= '0;
      end else if (restart_i || state == PH_IDLE) begin
        state <= PH_LOW;
        cnt   <= '0;
      end else if (tick_i) begin
        unique case (state)
          PH_LOW: begin
            low_mid_o <= (cnt == lo_half);
            if (cnt == lo_i) begin
              state <= PH_HIGH;
              cnt   <= '0;
            end else begin
              cnt <= cnt + PHASE_W'(1);
            end
          end
          PH_HIGH: begin
            if (scl_i) begin
              high_mid_o <= (cnt == hi_half);
              if (cnt == hi_i) begin
                state <= PH_LOW;
                cnt   <= '0;
              end else begin
                cnt <= cnt + PHASE_W'(1);
              end
            end
          end
          default: begin
            state <= PH_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer #(
  parameter int WORD_W  = 32,
  parameter int BASE_W  = 4,
  parameter int PHASE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [WORD_W-1:0] timing_i,
  input  logic              scl_i,
  output logic              scl_pull_o,
  output logic              sda_drive_stb_o,
  output logic              sda_sample_stb_o
);

  logic [BASE_W-1:0]  base;
  logic [PHASE_W-1:0] hi_cnt;
  logic [PHASE_W-1:0] lo_cnt;
  logic               tick;
  logic               tick_clr;

  scl_word_decode #(
    .WORD_W (WORD_W),
    .BASE_W (BASE_W),
    .PHASE_W(PHASE_W)
  ) decode_i (
    .word_i(timing_i),
    .base_o(base),
    .hi_o  (hi_cnt),
    .lo_o  (lo_cnt)
  );

  scl_tick_gen #(
    .BASE_W(BASE_W)
  ) tick_i (
    .clk   (clk),
    .rst   (rst),
    .clr_i (tick_clr),
    .base_i(base),
    .tick_o(tick)
  );

  scl_phase_fsm #(
    .PHASE_W(PHASE_W)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .restart_i (restart_i),
    .tick_i    (tick),
    .scl_i     (scl_i),
    .hi_i      (hi_cnt),
    .lo_i      (lo_cnt),
    .tick_clr_o(tick_clr),
    .pull_o    (scl_pull_o),
    .low_mid_o (sda_drive_stb_o),
    .high_mid_o(sda_sample_stb_o)
  );

endmodule

// File: rtl/i2c_scl_pacer_chk.sv
module i2c_scl_pacer_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic restart_i,
  input logic scl_i,
  input logic scl_pull_o,
  input logic sda_drive_stb_o,
  input logic sda_sample_stb_o
);

  p_off_released_r8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!scl_pull_o && !sda_drive_stb_o && !sda_sample_stb_o));

  p_restart_pulls_r9: assert property (@(posedge clk) disable iff (rst)
    (en_i && restart_i) |=> scl_pull_o);

  p_drive_stb_in_low_r6: assert property (@(posedge clk) disable iff (rst)
    sda_drive_stb_o |-> $past(scl_pull_o));

  p_sample_stb_in_high_r7: assert property (@(posedge clk) disable iff (rst)
    sda_sample_stb_o |-> ($past(!scl_pull_o) && $past(scl_i)));

  p_stretch_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en_i) && en_i && !restart_i && !scl_pull_o && !scl_i)
      |=> !scl_pull_o);

  p_strobes_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sda_drive_stb_o, sda_sample_stb_o}));

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (!scl_pull_o && !sda_drive_stb_o && !sda_sample_stb_o));

endmodule

bind i2c_scl_pacer i2c_scl_pacer_chk chk_i (
  .clk             (clk),
  .rst             (rst),
  .en_i            (en_i),
  .restart_i       (restart_i),
  .scl_i           (scl_i),
  .scl_pull_o      (scl_pull_o),
  .sda_drive_stb_o (sda_drive_stb_o),
  .sda_sample_stb_o(sda_sample_stb_o)
);

// File: tb/i2c_scl_pacer_tb.sv
module i2c_scl_pacer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        restart = 1'b0;
  logic        stretch = 1'b0;
  logic [31:0] timing = 32'd0;
  logic        scl_line;
  logic        pull;
  logic        drv_stb;
  logic        smp_stb;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign scl_line = ~pull & ~stretch;

  i2c_scl_pacer dut_i (
    .clk             (clk),
    .rst             (rst),
    .en_i            (en),
    .restart_i       (restart),
    .timing_i        (timing),
    .scl_i           (scl_line),
    .scl_pull_o      (pull),
    .sda_drive_stb_o (drv_stb),
    .sda_sample_stb_o(smp_stb)
  );

  function automatic logic [31:0] make_word(int b, int h, int l, logic [11:0] junk_hi,
                                            logic [7:0] junk_mid);
    return {junk_hi, h[3:0], l[3:0], junk_mid, b[3:0]};
  endfunction

  function automatic int low_len(int b, int l);
    return (l + 1) << b;
  endfunction

  function automatic int high_len(int b, int h);
    return (h + 1) << b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  task automatic configure(input logic [31:0] w);
    @(negedge clk);
    en = 1'b0;
    timing = w;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic wait_pull_start();
    int guard = 0;
    @(negedge clk);
    while (!pull && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Measures one period starting at the current sample, which must be a first low cycle.
  task automatic measure(input int b, input int h, input int l, output int per);
    int t = 0;
    int n_low = -1;
    int lo_at = -1;
    int hi_at = -1;
    int lo_n = 0;
    int hi_n = 0;
    logic prev = 1'b1;
    forever begin
      if (drv_stb) begin
        lo_n++;
        if (lo_at < 0) lo_at = t;
      end
      if (smp_stb && t > 0) begin
        hi_n++;
        if (hi_at < 0) hi_at = t;
      end
      if (t > 0 && pull && !prev) break;
      if (!pull && prev) n_low = t;
      prev = pull;
      @(negedge clk);
      t++;
      if (t > 100000) break;
    end
    per = t;
    check(n_low == low_len(b, l), "R1 low length", n_low, low_len(b, l));
    check(t - n_low == high_len(b, h), "R2 high length", t - n_low, high_len(b, h));
    check(lo_at == (((l >> 1) + 1) << b) && lo_n == 1, "R6 drive strobe offset",
          lo_at, ((l >> 1) + 1) << b);
    check(hi_at == low_len(b, l) + (((h >> 1) + 1) << b) && hi_n == 1,
          "R7 sample strobe offset", hi_at, low_len(b, l) + (((h >> 1) + 1) << b));
  endtask

  task automatic run_case(input int b, input int h, input int l, input logic [11:0] jh,
                          input logic [7:0] jm);
    int per;
    configure(make_word(b, h, l, jh, jm));
    wait_pull_start();
    measure(b, h, l, per);
    measure(b, h, l, per);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    int per;
    int n;
    int hi_at;
    int quiet;
    void'($urandom(32'd20250117));

    // R10: reset state
    repeat (3) @(negedge clk);
    check(!pull && !drv_stb && !smp_stb, "R10 outputs in reset", {pull, drv_stb, smp_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!pull && !drv_stb && !smp_stb, "R10 outputs after reset", {pull, drv_stb, smp_stb}, 0);

    // Directed corners
    run_case(0, 0, 0, 12'h000, 8'h00);
    run_case(2, 15, 15, 12'h000, 8'h00);
    run_case(7, 1, 1, 12'h000, 8'h00);
    run_case(1, 0, 15, 12'h000, 8'h00);

    // R3: field positions, base 2, hi 5, lo 9
    configure(32'h0005_9002);
    wait_pull_start();
    measure(2, 5, 9, per);
    check(per == 4 * (6 + 10), "R3 field decode period", per, 64);

    // R4: junk in unused bits leaves the waveform unchanged
    configure(32'hABC5_9FF2);
    wait_pull_start();
    measure(2, 5, 9, per);
    check(per == 64, "R4 unused bits ignored", per, 64);

    // Random mix
    for (int i = 0; i < 16; i++) begin
      int b = int'($urandom % 5);
      int h = int'($urandom % 16);
      int l = int'($urandom % 16);
      run_case(b, h, l, 12'($urandom), 8'($urandom));
    end

    // R5/R7: stretch with base 0, hi 3, lo 2, S = 5
    configure(make_word(0, 3, 2, 12'h0, 8'h0));
    wait_pull_start();
    while (pull) @(negedge clk);
    stretch = 1'b1;
    n = 0;
    hi_at = -1;
    while (!pull && n < 1000) begin
      if (smp_stb && hi_at < 0) hi_at = n;
      if (n == 5) stretch = 1'b0;
      n++;
      @(negedge clk);
    end
    stretch = 1'b0;
    check(n == 5 + 3 + 1, "R5 stretched high length", n, 9);
    check(hi_at == 5 + 1 + 1, "R7 sample strobe under stretch", hi_at, 7);

    // R8: disable mid low phase, then re-enable
    configure(make_word(1, 2, 3, 12'h0, 8'h0));
    wait_pull_start();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!pull && !drv_stb && !smp_stb, "R8 released after disable", {pull, drv_stb, smp_stb}, 0);
    quiet = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (pull || drv_stb || smp_stb) quiet++;
    end
    check(quiet == 0, "R8 stays released while disabled", quiet, 0);
    en = 1'b1;
    @(negedge clk);
    check(pull == 1'b1, "R8 low phase begins on enable", pull, 1);
    measure(1, 2, 3, per);

    // R9: restart in the high phase
    configure(make_word(1, 3, 2, 12'h0, 8'h0));
    wait_pull_start();
    while (pull) @(negedge clk);
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check(pull == 1'b1, "R9 pull after restart", pull, 1);
    n = 0;
    while (pull && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(n == low_len(1, 2), "R9 full low phase after restart", n, low_len(1, 2));

    en = 1'b0;
    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule